// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits between a synchronous host and an external asynchronous static RAM. The host hands it one access at a time: an address, a read or write flag, write data, and a valid/ready handshake. The block turns each access into a sequence of active-low strobes (chip enable, output enable, write enable), a latched address and a data bus with a separate direction control. Each phase of the sequence lasts a parameter number of clock cycles. The defaults are set so that a 100 MHz clock meets the limits of a 70 ns part: 70 ns address access, a 50 ns write pulse, 30 ns data setup and a 70 ns minimum cycle.

Writes are controlled by write enable. Chip enable falls with the address, write enable pulses inside the chip-enable window, the data is driven for the whole window, and output enable stays high throughout. Reads hold chip enable and output enable low until the access time has elapsed, and the data is sampled on the last cycle. Every access ends with a recovery interval in which all strobes are high.

A power-good input guards the memory. While it is low, and for a programmable number of cycles after it rises, chip enable stays high and no request is accepted. If power-good falls during an access, the access is abandoned: on the next clock all strobes go high and the bus is released, and no response is issued.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is applied and right after it, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 0 and rsp_valid is 0.
- R2: After pwr_good is high (following reset, or rising after a fall), mem_ce_n stays 1 and req_ready stays 0 for at least PWRUP_CYC cycles. A req_valid seen during that lockout starts no access.
- R3: mem_addr is loaded when a request is accepted (req_valid and req_ready high at a clock edge) and does not change while mem_ce_n is 0.
- R4: A read (req_write = 0) holds mem_ce_n and mem_oe_n low for exactly RD_CYC cycles, with mem_we_n = 1 and mem_dq_oe = 0. mem_dq_in is sampled at the end of that window.
- R5: A write (req_write = 1) holds mem_ce_n low for WS_CYC + WP_CYC + WH_CYC cycles. mem_we_n is low for exactly WP_CYC cycles after a setup of WS_CYC cycles. mem_dq_oe is 1 and mem_dq_out is stable for the whole write pulse.
- R6: mem_oe_n is 1 whenever mem_we_n is 0, and throughout every write.
- R7: Between two accesses all strobes stay high for at least REC_CYC cycles.
- R8: rsp_valid is a single-cycle pulse when an access completes. req_ready is 1 only while the block is idle with chip enable high.
- R9: In the clock after pwr_good is sampled low, all three strobes are 1 and mem_dq_oe is 0. An access cut short this way produces no rsp_valid.
- R10: A read returns on rsp_rdata the byte last written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Supply-in-tolerance indication, synchronous to clk |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Data captured by the last read |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The assertions assume that pwr_good is already synchronous to clk, and that the host keeps req_addr, req_write and req_wdata steady while req_valid is high and not yet accepted. The bench changes every input only on the falling clock edge. It holds each request until it sees req_ready, and drops pwr_good only at a falling edge in the middle of a write pulse. Its memory model returns unknown data until seven cycles of chip-enable-low have passed, so a read window that is too short shows up as a wrong read value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_LOCK  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_RD    = 3'd2,
    ST_WSET  = 3'd3,
    ST_WPUL  = 3'd4,
    ST_WHLD  = 3'd5,
    ST_RECOV = 3'd6
  } phase_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

  // R4 R5 R7: phase counter walks down one step per cycle when not reloaded
  p_timer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_pwr_guard.sv
module sram_pwr_guard #(
  parameter int PWRUP_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic locked
);

  localparam int CNT_W = $clog2(PWRUP_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PWRUP_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = !pwr_good || (cnt_q != LIMIT);
    cnt_d  = pwr_good ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign locked = (cnt_q != LIMIT);

  // R2: losing power always re-arms the lockout
  p_relock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> locked);

  // R2: lockout only ends after a cycle in which power was good
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(pwr_good));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int RD_CYC    = 8,
  parameter int WS_CYC    = 1,
  parameter int WP_CYC    = 6,
  parameter int WH_CYC    = 1,
  parameter int REC_CYC   = 1,
  parameter int PWRUP_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_A = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_B = (WS_CYC > WH_CYC) ? WS_CYC : WH_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_D = (MAX_C > REC_CYC) ? MAX_C : REC_CYC;
  localparam int TMR_W = $clog2(MAX_D + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // power guard and phase timer
  logic locked;
  logic tmr_load;
  logic tmr_last;
  logic [TMR_W-1:0] tmr_val;

  sram_pwr_guard #(.PWRUP_CYC(PWRUP_CYC)) u_guard (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pwr_good (pwr_good),
    .locked   (locked)
  );

  sram_phase_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  function automatic logic [TMR_W-1:0] phase_len(phase_t p);
    case (p)
      ST_RD:    phase_len = TMR_W'(RD_CYC - 1);
      ST_WSET:  phase_len = TMR_W'(WS_CYC - 1);
      ST_WPUL:  phase_len = TMR_W'(WP_CYC - 1);
      ST_WHLD:  phase_len = TMR_W'(WH_CYC - 1);
      ST_RECOV: phase_len = TMR_W'(REC_CYC - 1);
      default:  phase_len = '0;
    endcase
  endfunction

  // next-state logic
  phase_t state_q, state_d;
  logic   accept;
  logic   rd_done;
  logic   wr_done;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    rd_done = 1'b0;
    wr_done = 1'b0;
    case (state_q)
      ST_LOCK:  if (!locked) state_d = ST_IDLE;
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = req_write ? ST_WSET : ST_RD;
        end
      end
      ST_RD: begin
        if (tmr_last) begin
          rd_done = 1'b1;
          state_d = ST_RECOV;
        end
      end
      ST_WSET:  if (tmr_last) state_d = ST_WPUL;
      ST_WPUL:  if (tmr_last) state_d = ST_WHLD;
      ST_WHLD: begin
        if (tmr_last) begin
          wr_done = 1'b1;
          state_d = ST_RECOV;
        end
      end
      ST_RECOV: if (tmr_last) state_d = ST_IDLE;
      default:  state_d = ST_LOCK;
    endcase
    if (!pwr_good || locked) begin
      state_d = ST_LOCK;
      accept  = 1'b0;
      rd_done = 1'b0;
      wr_done = 1'b0;
    end
    tmr_load = (state_d != state_q);
    tmr_val  = phase_len(state_d);
  end

  // registers
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_LOCK;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rd_done || wr_done;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (rd_done) rdata_q <= mem_dq_in;
  end

  // strobe decode from the registered phase
  strobe_t stb;

  always_comb begin
    stb = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    case (state_q)
      ST_RD:   begin stb.ce_n = 1'b0; stb.oe_n = 1'b0; end
      ST_WSET: begin stb.ce_n = 1'b0; stb.dq_oe = 1'b1; end
      ST_WPUL: begin stb.ce_n = 1'b0; stb.we_n = 1'b0; stb.dq_oe = 1'b1; end
      ST_WHLD: begin stb.ce_n = 1'b0; stb.dq_oe = 1'b1; end
      default: ;
    endcase
  end

  assign mem_ce_n   = stb.ce_n;
  assign mem_oe_n   = stb.oe_n;
  assign mem_we_n   = stb.we_n;
  assign mem_dq_oe  = stb.dq_oe;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  // R3: address frozen while the chip is selected
  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R5: write pulse only inside a selected, driven window
  p_we_in_window_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

  // R5: data held through the write pulse
  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out));

  // R6: memory never drives while the controller drives
  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dq_oe |-> mem_oe_n);

  // R9: power loss releases everything on the next clock
  p_pwr_release_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pwr_good |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

  // R2: no chip select while the lockout is armed
  p_lock_deselect_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |-> mem_ce_n);

  // R8: completion is a single pulse, and ready means idle and deselected
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |=> !rsp_valid);
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (mem_ce_n && !rsp_valid));

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
module sram_cycle_ctrl_tb;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int RD = 8;
  localparam int WS = 1;
  localparam int WP = 6;
  localparam int WH = 1;
  localparam int RC = 1;
  localparam int PU = 200;
  localparam int ACCESS_CYC = 7;

  logic clk = 1'b0;
  logic rst_n, pwr_good, req_valid, req_ready, req_write, rsp_valid;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;

  always #5 clk = ~clk;

  sram_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WS_CYC(WS),
    .WP_CYC(WP), .WH_CYC(WH), .REC_CYC(RC), .PWRUP_CYC(PU)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in));

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and protocol monitor, sampled on falling edges
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int ce_len = 0, last_ce_len = 0, we_len = 0, last_we_len = 0;
  int hi_len = 1000, min_gap = 1000;
  int viol_addr = 0, viol_oe = 0, viol_data = 0, rsp_count = 0;
  logic prev_ce = 1'b1, prev_we = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dout = '0;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && ce_len >= ACCESS_CYC) ? mem[mem_addr] : 'x;

  always @(negedge clk) begin
    if (!mem_ce_n) begin
      if (prev_ce) begin
        ce_len = 1;
        if (hi_len < min_gap) min_gap = hi_len;
      end else begin
        ce_len = ce_len + 1;
        if (mem_addr != prev_addr) viol_addr++;
      end
      hi_len = 0;
    end else begin
      if (!prev_ce) last_ce_len = ce_len;
      ce_len = 0;
      hi_len = hi_len + 1;
    end
    if (!mem_we_n && !mem_oe_n) viol_oe++;
    if (!mem_ce_n && mem_dq_oe && !mem_oe_n) viol_oe++;
    if (!mem_we_n) begin
      we_len = we_len + 1;
      if (!mem_dq_oe) viol_data++;
      if (!prev_we && mem_dq_out != prev_dout) viol_data++;
    end else begin
      if (!prev_we) begin
        last_we_len = we_len;
        if (!prev_ce) mem[prev_addr] = prev_dout;
      end
      we_len = 0;
    end
    if (rsp_valid) rsp_count++;
    prev_ce = mem_ce_n;
    prev_we = mem_we_n;
    prev_addr = mem_addr;
    prev_dout = mem_dq_out;
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // hand one request over and wait for completion
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q);
    int rsp_cycles;
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    guard = 0;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 ready low while busy", req_ready, 0);
    rsp_cycles = 0;
    guard = 0;
    while (!rsp_valid && guard < 100) begin @(negedge clk); guard++; end
    q = rsp_rdata;
    while (rsp_valid) begin rsp_cycles++; @(negedge clk); end
    check(rsp_cycles == 1, "R8 rsp pulse width", rsp_cycles, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwr_good = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_oe && !req_ready && !rsp_valid, "R1 bus released in reset",
          {mem_dq_oe, req_ready, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && !mem_dq_oe && !req_ready, "R1 state after reset",
          {mem_ce_n, mem_dq_oe, req_ready}, 4);
  endtask

  task automatic t_lockout();
    int n = 0;
    int ce_lo = 0;
    int rsp0 = rsp_count;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h10; req_wdata = 8'hEE;
    while (!req_ready && n < PU + 50) begin
      if (n == PU / 2) req_valid = 1'b0;
      if (!mem_ce_n) ce_lo++;
      @(negedge clk); n++;
    end
    req_valid = 1'b0;
    check(n >= PU && n <= PU + 6, "R2 lockout length", n, PU);
    check(ce_lo == 0, "R2 chip enable held high in lockout", ce_lo, 0);
    repeat (3) @(negedge clk);
    check(mem_ce_n && rsp_count == rsp0, "R2 request in lockout ignored", rsp_count - rsp0, 0);
  endtask

  task automatic t_patterns();
    logic [AW-1:0] addrs [4] = '{11'h000, 11'h7FF, 11'h555, 11'h2AA};
    logic [DW-1:0] dats  [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    logic [DW-1:0] q;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, addrs[i], dats[i], q);
      check(last_we_len == WP, "R5 write pulse cycles", last_we_len, WP);
      check(last_ce_len == WS + WP + WH, "R5 write window cycles", last_ce_len, WS + WP + WH);
    end
    for (int i = 0; i < 4; i++) begin
      access(1'b0, addrs[i], 8'h00, q);
      check(q === dats[i], "R10 read back", q, dats[i]);
      check(last_ce_len == RD, "R4 read window cycles", last_ce_len, RD);
    end
    check(viol_addr == 0, "R3 address stable", viol_addr, 0);
    check(viol_oe == 0, "R6 output enable high in writes", viol_oe, 0);
    check(viol_data == 0, "R5 data driven and stable", viol_data, 0);
  endtask

  task automatic t_back_to_back();
    logic [DW-1:0] q;
    min_gap = 1000;
    access(1'b1, 11'h123, 8'h3C, q);
    access(1'b1, 11'h124, 8'hC3, q);
    access(1'b0, 11'h123, 8'h00, q);
    check(q === 8'h3C, "R10 neighbour write kept", q, 8'h3C);
    check(min_gap >= RC, "R7 recovery gap", min_gap, RC);
  endtask

  task automatic t_power_fail();
    int guard = 0;
    int n = 0;
    int rsp0;
    logic [DW-1:0] q;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 11'h200; req_wdata = 8'h77;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (mem_we_n && guard < 20) begin @(negedge clk); guard++; end
    check(!mem_we_n, "R9 write pulse reached before fail", mem_we_n, 0);
    rsp0 = rsp_count;
    pwr_good = 1'b0;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R9 strobes released",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 14);
    repeat (10) @(negedge clk);
    check(rsp_count == rsp0, "R9 no response for aborted write", rsp_count - rsp0, 0);
    pwr_good = 1'b1;
    while (!req_ready && n < PU + 50) begin @(negedge clk); n++; end
    check(n >= PU, "R2 lockout after power return", n, PU);
    access(1'b0, 11'h7FF, 8'h00, q);
    check(q === 8'hFF, "R10 other data kept after power fail", q, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_patterns();
    t_back_to_back();
    t_power_fail();
    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule